// File: doc/BRIEF.md
# Byte-Lane Bus Source Multiplexer

This block owns a 16-bit internal data bus and decides, once per clock, what the bus carries next. A 5-bit source code together with an enable bit picks the next value. The bus can take a whole word from the program counter, the stack pointer or RAM read data, or it can take one or two bytes from four 8-bit general registers, the ALU result byte or the status byte. When a byte-wide source drives the low lane, it can push the previous low byte up into the high lane. That lets microcode build a 16-bit word over two cycles from two single-byte drives.

The block also contains the state the bus feeds and reads. Each of the four general registers has a low-lane load strobe and a high-lane load strobe. The program counter can increment or load from the bus. The stack pointer can count up or down, or load from the bus. The bus is registered. Every load strobe samples the bus value held before the same clock edge, so a drive and a load in one cycle form a clean one-cycle transfer. The ALU and the microcode sequencer sit outside the block.

Top module: `lane_bus_mux`

## Requirements
- R1: While reset is active and right after it, the bus reads 0x0000, the program counter 0x0000 and the stack pointer 0xFFFF.
- R2: With the enable set, code 0 loads the program counter onto the bus and code 1 loads the stack pointer, on the following clock edge.
- R3: Codes 2, 4, 6 and 8 drive registers A, B, C and D into bits 7:0. In the same edge the previous bus bits 7:0 move to bits 15:8.
- R4: Codes 3, 5, 7 and 9 drive registers A, B, C and D into bits 15:8 and leave bits 7:0 unchanged.
- R5: Codes 10 to 21 drive a register pair. The first register goes in bits 7:0 and the second in bits 15:8, in the order AB, AC, AD, BA, BC, BD, CA, CB, CD, DA, DB, DC.
- R6: Code 29 places the ALU byte in bits 7:0 and leaves bits 15:8 unchanged.
- R7: Code 30 places the status byte in bits 7:0 and moves the previous bits 7:0 to bits 15:8.
- R8: Code 31 places the 16-bit RAM read data on the bus.
- R9: When the enable is clear, or when the code is 22 to 28, the bus keeps its value.
- R10: Register i (0=A … 3=D) loads bus bits 7:0 on loadLo[i] and bus bits 15:8 on loadHi[i]. If both strobes are set, the high lane wins. Loads take the bus value from before the edge.
- R11: The program counter loads the bus on pcLoad, which takes priority. Otherwise it increments on pcInc and wraps from 0xFFFF to 0x0000.
- R12: The stack pointer loads the bus on spLoad, which takes priority. Otherwise it steps on spCount, down when spDown is set and up otherwise, and wraps in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEn | input | 1 | Bus drive enable |
| srcSel | input | 5 | Bus source code |
| aluByte | input | 8 | ALU result byte |
| statusByte | input | 8 | Status byte |
| ramData | input | 16 | RAM read data |
| loadLo | input | 4 | Per-register low-lane load strobes |
| loadHi | input | 4 | Per-register high-lane load strobes |
| pcInc | input | 1 | Program counter increment |
| pcLoad | input | 1 | Program counter load from bus |
| spCount | input | 1 | Stack pointer step |
| spDown | input | 1 | Stack pointer step direction, 1 = down |
| spLoad | input | 1 | Stack pointer load from bus |
| bus | output | 16 | Registered data bus |
| pcOut | output | 16 | Program counter value |
| spOut | output | 16 | Stack pointer value |

## Verification
The general registers have no output port of their own, so their contents can be seen only by driving them back onto the bus. Each test therefore runs in three steps: put a known word on the bus with the RAM code, strobe a register load, then select a single or paired code. The shifting low-lane rule needs a known previous bus word. The bench sets that word up with a RAM drive in the cycle just before the byte drive, and then checks both lanes. The wrap of the program counter is reached by loading 0xFFFF from the bus before an increment.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  localparam int DATA_W  = 16;
  localparam int NUM_GPR = 4;
  localparam int SEL_W   = 5;
  localparam int IDX_W   = $clog2(NUM_GPR);

  typedef enum logic [2:0] {
    SRC_PC, SRC_SP, SRC_LO_SHIFT, SRC_HI_KEEP,
    SRC_PAIR, SRC_ALU_LO, SRC_STATUS_SHIFT, SRC_RAM
  } srcMode_e;

  typedef struct packed {
    logic               drive;
    srcMode_e           mode;
    logic [IDX_W-1:0]   loIdx;
    logic [IDX_W-1:0]   hiIdx;
    logic [NUM_GPR-1:0] loadLo;
    logic [NUM_GPR-1:0] loadHi;
    logic               pcInc;
    logic               pcLoad;
    logic               spCount;
    logic               spDown;
    logic               spLoad;
  } busCtrl_t;
endpackage

// File: rtl/lbm_ctrl.sv
module lbm_ctrl
  import lbm_pkg::*;
(
  input  logic               srcEn,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [NUM_GPR-1:0] loadLo,
  input  logic [NUM_GPR-1:0] loadHi,
  input  logic               pcInc,
  input  logic               pcLoad,
  input  logic               spCount,
  input  logic               spDown,
  input  logic               spLoad,
  output busCtrl_t           ctrl
);
  localparam int SINGLE_BASE = 2;
  localparam int PAIR_BASE   = SINGLE_BASE + 2 * NUM_GPR;
  localparam int CODE_RAM    = (1 << SEL_W) - 1;
  localparam int CODE_STATUS = CODE_RAM - 1;
  localparam int CODE_ALU    = CODE_RAM - 2;

  always_comb begin
    ctrl         = '0;
    ctrl.mode    = SRC_PC;
    ctrl.loadLo  = loadLo;
    ctrl.loadHi  = loadHi;
    ctrl.pcInc   = pcInc;
    ctrl.pcLoad  = pcLoad;
    ctrl.spCount = spCount;
    ctrl.spDown  = spDown;
    ctrl.spLoad  = spLoad;
    if (srcEn) begin
      if (int'(srcSel) == 0) begin
        ctrl.drive = 1'b1;
        ctrl.mode  = SRC_PC;
      end
      if (int'(srcSel) == 1) begin
        ctrl.drive = 1'b1;
        ctrl.mode  = SRC_SP;
      end
      for (int i = 0; i < NUM_GPR; i++) begin
        if (int'(srcSel) == SINGLE_BASE + 2 * i) begin
          ctrl.drive = 1'b1;
          ctrl.mode  = SRC_LO_SHIFT;
          ctrl.loIdx = IDX_W'(i);
        end
        if (int'(srcSel) == SINGLE_BASE + 2 * i + 1) begin
          ctrl.drive = 1'b1;
          ctrl.mode  = SRC_HI_KEEP;
          ctrl.loIdx = IDX_W'(i);
        end
      end
      for (int lo = 0; lo < NUM_GPR; lo++) begin
        for (int hi = 0; hi < NUM_GPR; hi++) begin
          if (lo != hi &&
              int'(srcSel) == PAIR_BASE + lo * (NUM_GPR - 1) + ((hi < lo) ? hi : hi - 1)) begin
            ctrl.drive = 1'b1;
            ctrl.mode  = SRC_PAIR;
            ctrl.loIdx = IDX_W'(lo);
            ctrl.hiIdx = IDX_W'(hi);
          end
        end
      end
      if (int'(srcSel) == CODE_ALU) begin
        ctrl.drive = 1'b1;
        ctrl.mode  = SRC_ALU_LO;
      end
      if (int'(srcSel) == CODE_STATUS) begin
        ctrl.drive = 1'b1;
        ctrl.mode  = SRC_STATUS_SHIFT;
      end
      if (int'(srcSel) == CODE_RAM) begin
        ctrl.drive = 1'b1;
        ctrl.mode  = SRC_RAM;
      end
    end
  end
endmodule

// File: rtl/lbm_datapath.sv
module lbm_datapath
  import lbm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busCtrl_t          ctrl,
  input  logic [DATA_W/2-1:0] aluByte,
  input  logic [DATA_W/2-1:0] statusByte,
  input  logic [DATA_W-1:0] ramData,
  output logic [DATA_W-1:0] bus,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0]   gpr [NUM_GPR];
  logic [DATA_W-1:0] busNext;
  logic [HALF-1:0]   loByte;

  assign loByte = bus[HALF-1:0];

  always_comb begin
    busNext = bus;
    case (ctrl.mode)
      SRC_PC:           busNext = pcOut;
      SRC_SP:           busNext = spOut;
      SRC_LO_SHIFT:     busNext = {loByte, gpr[ctrl.loIdx]};
      SRC_HI_KEEP:      busNext = {gpr[ctrl.loIdx], loByte};
      SRC_PAIR:         busNext = {gpr[ctrl.hiIdx], gpr[ctrl.loIdx]};
      SRC_ALU_LO:       busNext = {bus[DATA_W-1:HALF], aluByte};
      SRC_STATUS_SHIFT: busNext = {loByte, statusByte};
      SRC_RAM:          busNext = ramData;
      default:          busNext = bus;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bus <= '0;
    else if (ctrl.drive) bus <= busNext;
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : gGpr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                gpr[g] <= '0;
      else if (ctrl.loadHi[g])  gpr[g] <= bus[DATA_W-1:HALF];
      else if (ctrl.loadLo[g])  gpr[g] <= loByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pcOut <= '0;
    else if (ctrl.pcLoad)  pcOut <= bus;
    else if (ctrl.pcInc)   pcOut <= pcOut + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             spOut <= '1;
    else if (ctrl.spLoad)  spOut <= bus;
    else if (ctrl.spCount) spOut <= ctrl.spDown ? spOut - 1'b1 : spOut + 1'b1;
  end
endmodule

// File: rtl/lane_bus_mux.sv
module lane_bus_mux
  import lbm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               srcEn,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [DATA_W/2-1:0] aluByte,
  input  logic [DATA_W/2-1:0] statusByte,
  input  logic [DATA_W-1:0]  ramData,
  input  logic [NUM_GPR-1:0] loadLo,
  input  logic [NUM_GPR-1:0] loadHi,
  input  logic               pcInc,
  input  logic               pcLoad,
  input  logic               spCount,
  input  logic               spDown,
  input  logic               spLoad,
  output logic [DATA_W-1:0]  bus,
  output logic [DATA_W-1:0]  pcOut,
  output logic [DATA_W-1:0]  spOut
);
  busCtrl_t ctrl;

  lbm_ctrl u_ctrl (
    .srcEn(srcEn), .srcSel(srcSel), .loadLo(loadLo), .loadHi(loadHi),
    .pcInc(pcInc), .pcLoad(pcLoad), .spCount(spCount), .spDown(spDown),
    .spLoad(spLoad), .ctrl(ctrl)
  );

  lbm_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .aluByte(aluByte),
    .statusByte(statusByte), .ramData(ramData), .bus(bus),
    .pcOut(pcOut), .spOut(spOut)
  );
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        srcEn,
  input logic [4:0]  srcSel,
  input logic [7:0]  aluByte,
  input logic [15:0] ramData,
  input logic        pcInc,
  input logic        pcLoad,
  input logic        spCount,
  input logic        spDown,
  input logic        spLoad,
  input logic [15:0] bus,
  input logic [15:0] pcOut,
  input logic [15:0] spOut
);
  // R2
  sp_word_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn && srcSel == 5'd1) |=> bus == $past(spOut));
  // R3
  low_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn && srcSel >= 5'd2 && srcSel <= 5'd8 && !srcSel[0]) |=> bus[15:8] == $past(bus[7:0]));
  // R4
  high_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn && srcSel >= 5'd3 && srcSel <= 5'd9 && srcSel[0]) |=> bus[7:0] == $past(bus[7:0]));
  // R6
  alu_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn && srcSel == 5'd29) |=> (bus[7:0] == $past(aluByte) && bus[15:8] == $past(bus[15:8])));
  // R8
  ram_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn && srcSel == 5'd31) |=> bus == $past(ramData));
  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcEn || (srcSel >= 5'd22 && srcSel <= 5'd28)) |=> $stable(bus));
  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcInc && !pcLoad) |=> pcOut == $past(pcOut) + 16'd1);
  // R12
  sp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spCount && !spLoad) |=> spOut == ($past(spDown) ? $past(spOut) - 16'd1 : $past(spOut) + 16'd1));
endmodule

bind lane_bus_mux lbm_checker u_lbm_checker (
  .clk(clk), .rstN(rstN), .srcEn(srcEn), .srcSel(srcSel), .aluByte(aluByte),
  .ramData(ramData), .pcInc(pcInc), .pcLoad(pcLoad), .spCount(spCount),
  .spDown(spDown), .spLoad(spLoad), .bus(bus), .pcOut(pcOut), .spOut(spOut)
);

// File: tb/tb_lane_bus_mux.sv
module tb_lane_bus_mux;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srcEn = 1'b0;
  logic [4:0]  srcSel = '0;
  logic [7:0]  aluByte = '0;
  logic [7:0]  statusByte = '0;
  logic [15:0] ramData = '0;
  logic [3:0]  loadLo = '0;
  logic [3:0]  loadHi = '0;
  logic        pcInc = 1'b0, pcLoad = 1'b0, spCount = 1'b0, spDown = 1'b0, spLoad = 1'b0;
  logic [15:0] bus, pcOut, spOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] regVal [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lane_bus_mux dut (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .srcSel(srcSel), .aluByte(aluByte),
    .statusByte(statusByte), .ramData(ramData), .loadLo(loadLo), .loadHi(loadHi),
    .pcInc(pcInc), .pcLoad(pcLoad), .spCount(spCount), .spDown(spDown),
    .spLoad(spLoad), .bus(bus), .pcOut(pcOut), .spOut(spOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic driveCode(input logic [4:0] c);
    srcSel = c; srcEn = 1'b1;
    @(negedge clk);
    srcEn = 1'b0;
  endtask

  task automatic putBus(input logic [15:0] v);
    ramData = v;
    driveCode(5'd31);
  endtask

  task automatic loadReg(input int i, input logic [7:0] v);
    putBus({8'h00, v});
    loadLo[i] = 1'b1;
    @(negedge clk);
    loadLo = '0;
    regVal[i] = v;
  endtask

  task automatic testReset();
    check("R1 bus", bus, 16'h0000);
    check("R1 pc", pcOut, 16'h0000);
    check("R1 sp", spOut, 16'hFFFF);
  endtask

  task automatic testRamAndHold();
    putBus(16'h5AA5);
    check("R8 ram word", bus, 16'h5AA5);
    ramData = 16'h1111; srcSel = 5'd31; srcEn = 1'b0;
    @(negedge clk);
    check("R9 enable low", bus, 16'h5AA5);
    for (int c = 22; c <= 28; c++) begin
      driveCode(5'(c));
      check("R9 unused code", bus, 16'h5AA5);
    end
  endtask

  task automatic testSingles();
    loadReg(0, 8'h11); loadReg(1, 8'h22); loadReg(2, 8'h33); loadReg(3, 8'h44);
    for (int i = 0; i < 4; i++) begin
      putBus(16'h12AB);
      driveCode(5'(2 + 2 * i));
      check("R3 low shift", bus, {8'hAB, regVal[i]});
      putBus(16'h1234);
      driveCode(5'(3 + 2 * i));
      check("R4 high keep", bus, {regVal[i], 8'h34});
    end
  endtask

  task automatic testPairs();
    int code = 10;
    for (int lo = 0; lo < 4; lo++) begin
      for (int hi = 0; hi < 4; hi++) begin
        if (lo != hi) begin
          putBus(16'h0000);
          driveCode(5'(code));
          check("R5 pair", bus, {regVal[hi], regVal[lo]});
          code++;
        end
      end
    end
  endtask

  task automatic testAluStatus();
    putBus(16'hBEEF);
    aluByte = 8'h77;
    driveCode(5'd29);
    check("R6 alu low", bus, 16'hBE77);
    putBus(16'h00C4);
    statusByte = 8'h03;
    driveCode(5'd30);
    check("R7 status shift", bus, 16'hC403);
  endtask

  task automatic testRegLoads();
    putBus(16'hA5C3);
    loadLo[2] = 1'b1; loadHi[2] = 1'b1;
    @(negedge clk);
    loadLo = '0; loadHi = '0;
    driveCode(5'd6);
    check("R10 high wins", bus, 16'hC3A5);
    putBus(16'h1E2F);
    loadHi[3] = 1'b1;
    @(negedge clk);
    loadHi = '0;
    driveCode(5'd8);
    check("R10 high lane load", bus, 16'h2F1E);
  endtask

  task automatic testPcSp();
    putBus(16'hFFFF);
    pcLoad = 1'b1; pcInc = 1'b1;
    @(negedge clk);
    pcLoad = 1'b0;
    check("R11 load priority", pcOut, 16'hFFFF);
    @(negedge clk);
    pcInc = 1'b0;
    check("R11 wrap", pcOut, 16'h0000);
    driveCode(5'd0);
    check("R2 pc drive", bus, 16'h0000);
    spCount = 1'b1; spDown = 1'b0;
    @(negedge clk);
    check("R12 up wrap", spOut, 16'h0000);
    spDown = 1'b1;
    @(negedge clk);
    check("R12 down wrap", spOut, 16'hFFFF);
    @(negedge clk);
    spCount = 1'b0;
    check("R12 down step", spOut, 16'hFFFE);
    driveCode(5'd1);
    check("R2 sp drive", bus, 16'hFFFE);
    putBus(16'h4321);
    spLoad = 1'b1; spCount = 1'b1;
    @(negedge clk);
    spLoad = 1'b0; spCount = 1'b0;
    check("R12 load priority", spOut, 16'h4321);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRamAndHold();
    testSingles();
    testPairs();
    testAluStatus();
    testRegLoads();
    testPcSp();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule